// File: doc/BRIEF.md
# Video Clamp Timing Generator

This block times the black-level clamp window for a three-channel video digitizer, counting in pixel clocks. It watches the horizontal sync input, brings it into the pixel clock domain, and finds the end of each sync pulse. From that trailing edge it waits a programmable number of pixels, then raises a single clamp-active output for a programmed number of pixels. The timing hangs off the end of sync, not its start, because the sync width varies a great deal between video modes while the back porch always comes straight after it.

A mode bit hands clamp timing to an external clamp pin, with a selectable active level, and bypasses the internal counter. For each of the three channels the block also drives the code that channel clamps to: either the bottom of the converter range or its midscale. Settings are loaded through a small parallel write port.

Top module: `clamp_timing_gen`

## Requirements
- R1: After reset the start-delay register is 0x09, the length register is 0x14, the control register is 0, `clamp_out` is 0 and all target codes are 0x00. With these values each line gives a 20-cycle clamp.
- R2: `hsync_in` passes through a two-flop synchronizer. Let edge k be the first rising clock edge that samples the trailing sync level. With start delay D and length L (L > 0), `clamp_out` is high in the L cycles that follow edges k+2+D through k+1+D+L. This holds for any sync pulse width.
- R3: A start delay of 0 raises `clamp_out` right after edge k+2.
- R4: A length of 0 gives no clamp on that line.
- R5: Control bit 5 sets the sync polarity. With 0, sync is active high and its falling edge is the trailing edge. With 1, sync is active low and its rising edge is the trailing edge.
- R6: A trailing edge that arrives while a delay or a clamp is still running aborts it and starts a new delay count using the current settings.
- R7: Writes to the delay and length registers take effect only at the next trailing edge. A window already in progress keeps its old delay and length.
- R8: While control bit 3 is 1, `clamp_out` is `ext_clamp_in` registered by one clock edge. It is inverted when control bit 4 is 1, so the pin is then active low. Changes to control bits take effect from the edge after the write.
- R9: Control bits 0, 1 and 2 select the target for channels 0, 1 and 2. A 0 gives 0x00 and a 1 gives 0x80. Channel i drives `tgt_codes[8i+7:8i]`, which changes on the edge that performs the write.
- R10: Write address 0 holds the start delay, address 1 holds the length and address 2 holds the control register. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync, asynchronous to clk |
| ext_clamp_in | input | 1 | External clamp pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| clamp_out | output | 1 | Registered clamp-active signal shared by all channels |
| tgt_codes | output | 24 | Clamp target code for each channel, 8 bits per channel |

## Verification
Sync pulses of different widths confirm that the window is counted from the trailing edge and not the leading one. Sync gaps shorter than delay plus length force the abort-and-restart path, both while the delay is running and while the clamp is running. Delay 0 and length 0 lines exercise the two counter boundary cases. Writes made during a line separate the register shadowing from immediate use. Running the same pulse pattern under inverted sync polarity, and driving the external pin under both polarities, covers the mode and polarity bits.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
   localparam int NCH = 3;
   localparam int CTRL_W = 6;
   localparam int CB_EXT_EN  = 3;
   localparam int CB_EXT_POL = 4;
   localparam int CB_SYNC_AL = 5;
   localparam logic [1:0] A_DELAY = 2'd0;
   localparam logic [1:0] A_LEN   = 2'd1;
   localparam logic [1:0] A_CTRL  = 2'd2;
   typedef enum logic [1:0] {TS_IDLE, TS_WAIT, TS_CLAMP} tstate_t;
endpackage

// File: rtl/hsync_trail_det.sv
module hsync_trail_det #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_in,
   input  logic active_low,
   output logic trail
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hsync_trail_det: STAGES must be at least 2");
   end

   logic [STAGES:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[0] <= 1'b0;
      else        q[0] <= sync_in;
   end

   for (genvar i = 1; i <= STAGES; i++) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q[i] <= 1'b0;
         else        q[i] <= q[i-1];
      end
   end

   assign trail = active_low ? (!q[STAGES] && q[STAGES-1])
                             : (q[STAGES] && !q[STAGES-1]);

   // R2: one trailing edge is a single-cycle event
   p_trail_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      trail |=> !trail);
endmodule

// File: rtl/clamp_cfg_regs.sv
module clamp_cfg_regs
   import clamp_pkg::*;
#(
   parameter int REG_W = 8,
   parameter int ADDR_W = 2,
   parameter logic [REG_W-1:0] DELAY_RST = 8'h09,
   parameter logic [REG_W-1:0] LEN_RST = 8'h14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  delay_q,
   output logic [REG_W-1:0]  len_q,
   output logic [CTRL_W-1:0] ctrl_q
);
   if (REG_W < CTRL_W) begin : g_bad_width
      $error("clamp_cfg_regs: REG_W too narrow for the control field");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         delay_q <= DELAY_RST;
         len_q   <= LEN_RST;
         ctrl_q  <= '0;
      end else if (wr_en) begin
         case (wr_addr[1:0])
            A_DELAY: delay_q <= wr_data;
            A_LEN:   len_q   <= wr_data;
            A_CTRL:  ctrl_q  <= wr_data[CTRL_W-1:0];
            default: ;
         endcase
      end
   end

   // R10: an unmapped address leaves every register as it was
   p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[1:0] == 2'd3) |=>
         ($stable(delay_q) && $stable(len_q) && $stable(ctrl_q)));
endmodule

// File: rtl/clamp_window_timer.sv
module clamp_window_timer
   import clamp_pkg::*;
#(
   parameter int REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trail,
   input  logic [REG_W-1:0] delay_in,
   input  logic [REG_W-1:0] len_in,
   output logic             clamp_nxt
);
   localparam logic [REG_W-1:0] ONE = REG_W'(1);

   tstate_t          st, st_n;
   logic [REG_W-1:0] cnt, cnt_n;
   logic [REG_W-1:0] len_act, len_n;

   always_comb begin
      st_n  = st;
      cnt_n = cnt;
      len_n = len_act;
      if (trail) begin
         len_n = len_in;
         if (len_in == '0) begin
            st_n = TS_IDLE;
         end else if (delay_in == '0) begin
            st_n  = TS_CLAMP;
            cnt_n = len_in - ONE;
         end else begin
            st_n  = TS_WAIT;
            cnt_n = delay_in - ONE;
         end
      end else begin
         case (st)
            TS_WAIT:
               if (cnt == '0) begin
                  st_n  = TS_CLAMP;
                  cnt_n = len_act - ONE;
               end else begin
                  cnt_n = cnt - ONE;
               end
            TS_CLAMP:
               if (cnt == '0) st_n = TS_IDLE;
               else           cnt_n = cnt - ONE;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= TS_IDLE;
         cnt     <= '0;
         len_act <= '0;
      end else begin
         st      <= st_n;
         cnt     <= cnt_n;
         len_act <= len_n;
      end
   end

   assign clamp_nxt = (st_n == TS_CLAMP);

   // checker: clamp cycles since the last trailing edge
   logic [REG_W:0] run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           run <= '0;
      else if (trail)       run <= (st_n == TS_CLAMP) ? 1 : 0;
      else if (st_n == TS_CLAMP) run <= run + 1'b1;
   end

   p_window_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      run <= {1'b0, len_act});
   p_zero_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (trail && delay_in == '0 && len_in != '0) |=> st == TS_CLAMP);
   p_zero_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (trail && len_in == '0) |=> st == TS_IDLE);
   p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (trail && delay_in != '0 && len_in != '0) |=> st == TS_WAIT);
endmodule

// File: rtl/clamp_timing_gen.sv
module clamp_timing_gen
   import clamp_pkg::*;
#(
   parameter int REG_W = 8,
   parameter int ADDR_W = 2,
   parameter int SYNC_STAGES = 2,
   parameter logic [REG_W-1:0] DELAY_RST = 8'h09,
   parameter logic [REG_W-1:0] LEN_RST = 8'h14
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   hsync_in,
   input  logic                   ext_clamp_in,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [REG_W-1:0]       wr_data,
   output logic                   clamp_out,
   output logic [NCH*REG_W-1:0]   tgt_codes
);
   localparam logic [REG_W-1:0] MID_CODE = REG_W'(1) << (REG_W - 1);

   if (ADDR_W < 2) begin : g_bad_addr
      $error("clamp_timing_gen: ADDR_W must be at least 2");
   end
   if (REG_W < 2) begin : g_bad_reg
      $error("clamp_timing_gen: REG_W must be at least 2");
   end

   logic [REG_W-1:0]  delay_q, len_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic              trail, clamp_nxt;

   clamp_cfg_regs #(
      .REG_W(REG_W), .ADDR_W(ADDR_W),
      .DELAY_RST(DELAY_RST), .LEN_RST(LEN_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .delay_q(delay_q), .len_q(len_q), .ctrl_q(ctrl_q)
   );

   hsync_trail_det #(.STAGES(SYNC_STAGES)) u_det (
      .clk(clk), .rst_n(rst_n), .sync_in(hsync_in),
      .active_low(ctrl_q[CB_SYNC_AL]), .trail(trail)
   );

   clamp_window_timer #(.REG_W(REG_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .trail(trail),
      .delay_in(delay_q), .len_in(len_q), .clamp_nxt(clamp_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  clamp_out <= 1'b0;
      else if (ctrl_q[CB_EXT_EN])  clamp_out <= ext_clamp_in ^ ctrl_q[CB_EXT_POL];
      else                         clamp_out <= clamp_nxt;
   end

   for (genvar i = 0; i < NCH; i++) begin : g_tgt
      assign tgt_codes[i*REG_W +: REG_W] = ctrl_q[i] ? MID_CODE : '0;

      // R9: a control write sets this channel's target from its select bit
      p_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_addr[1:0] == A_CTRL) |=>
            tgt_codes[i*REG_W +: REG_W] == ($past(wr_data[i]) ? MID_CODE : '0));
   end

   // R8: in external mode the output follows the pin one edge later
   p_ext_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[CB_EXT_EN] |=>
         clamp_out == ($past(ext_clamp_in) ^ $past(ctrl_q[CB_EXT_POL])));
endmodule

// File: tb/sim_clamp_timing_gen.sv
`timescale 1ns/1ps
module sim_clamp_timing_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hsync_in = 1'b0;
   logic        ext_clamp_in = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [7:0]  wr_data = 8'd0;
   logic        clamp_out;
   logic [23:0] tgt_codes;

   clamp_timing_gen u0 (
      .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .ext_clamp_in(ext_clamp_in),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .clamp_out(clamp_out), .tgt_codes(tgt_codes)
   );

   always #2.5 clk = ~clk;

   int total = 0;
   int bad = 0;
   int wd = 0;
   bit done = 0;
   bit cmp_on = 0;
   string cur_req = "R1";
   bit sync_al = 0;
   int hi_cnt = 0;

   // behavioural reference model
   int  m_delay, m_len, m_ctrl, cyc, t_n, t_d, t_l;
   bit  h1, h2, h3, t_valid, m_clamp, trl, int_nxt;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_delay = 9; m_len = 20; m_ctrl = 0; cyc = 0;
         h1 = 0; h2 = 0; h3 = 0; t_valid = 0; m_clamp = 0;
      end else begin
         trl = m_ctrl[5] ? (!h3 && h2) : (h3 && !h2);
         if (trl) begin
            t_valid = 1; t_n = cyc; t_d = m_delay; t_l = m_len;
         end
         int_nxt = t_valid && (cyc >= t_n + t_d) && (cyc < t_n + t_d + t_l);
         m_clamp = m_ctrl[3] ? (ext_clamp_in ^ m_ctrl[4]) : int_nxt;
         h3 = h2; h2 = h1; h1 = hsync_in;
         if (wr_en) begin
            case (wr_addr)
               2'd0: m_delay = wr_data;
               2'd1: m_len = wr_data;
               2'd2: m_ctrl = wr_data & 8'h3f;
               default: ;
            endcase
         end
         cyc++;
      end
   end

   function automatic logic [23:0] exp_tgt(int c);
      logic [23:0] v;
      for (int i = 0; i < 3; i++) v[i*8 +: 8] = c[i] ? 8'h80 : 8'h00;
      return v;
   endfunction

   always @(negedge clk) begin
      if (rst_n && cmp_on && !done) begin
         total++;
         if (clamp_out !== m_clamp) begin
            bad++;
            $display("FAIL %s clamp_out act=%0b exp=%0b at cycle %0d", cur_req, clamp_out, m_clamp, cyc);
         end
         total++;
         if (tgt_codes !== exp_tgt(m_ctrl)) begin
            bad++;
            $display("FAIL %s tgt_codes act=%h exp=%h", cur_req, tgt_codes, exp_tgt(m_ctrl));
         end
         if (clamp_out) hi_cnt++;
      end
   end

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic wr(int a, int d);
      wr_en = 1; wr_addr = a[1:0]; wr_data = d[7:0];
      tick(1);
      wr_en = 0;
   endtask

   task automatic hline(int width, int gap);
      hsync_in = !sync_al;
      tick(width);
      hsync_in = sync_al;
      tick(gap);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 150000 && !done) begin
         total++; bad++;
         $display("FAIL watchdog %s act=timeout exp=finish", cur_req);
         finish_run();
      end
   end

   initial begin
      tick(3);
      #1;
      check("R1 clamp_out in reset", int'(clamp_out), 0);
      check("R1 tgt_codes in reset", int'(tgt_codes), 0);
      rst_n = 1;
      tick(1);
      cmp_on = 1;

      cur_req = "R1";
      hi_cnt = 0;
      hline(10, 60);
      check("R1 default clamp length", hi_cnt, 20);

      cur_req = "R2";
      hline(3, 40); hline(25, 40); hline(1, 40);

      cur_req = "R3";
      wr(0, 0); wr(1, 5);
      hline(4, 20); hline(4, 20);

      cur_req = "R4";
      wr(1, 0);
      hi_cnt = 0;
      hline(4, 30);
      check("R4 zero length line", hi_cnt, 0);

      cur_req = "R6";
      wr(0, 20); wr(1, 20);
      hline(5, 12); hline(5, 50);
      wr(0, 2); wr(1, 30);
      hline(3, 15); hline(3, 45);

      cur_req = "R7";
      wr(0, 10); wr(1, 8);
      hline(3, 5);
      wr(1, 3); wr(0, 1);
      hline(3, 25); hline(3, 25);

      cur_req = "R10";
      wr(3, 8'hff);
      hline(3, 25);

      cur_req = "R5";
      wr(2, 8'h20);
      sync_al = 1;
      hsync_in = 1;
      tick(20);
      hline(6, 25); hline(2, 25);

      cur_req = "R8";
      wr(2, 8'h28);
      for (int i = 0; i < 12; i++) begin ext_clamp_in = i[1] ^ i[0]; tick(1); end
      hline(3, 10);
      wr(2, 8'h38);
      for (int i = 0; i < 12; i++) begin ext_clamp_in = i[2]; tick(1); end
      wr(2, 8'h20);
      ext_clamp_in = 0;
      hline(3, 25);

      cur_req = "R9";
      wr(2, 8'h21); tick(2);
      check("R9 channel 0 midscale", int'(tgt_codes), 24'h000080);
      wr(2, 8'h22); tick(2);
      wr(2, 8'h24); tick(2);
      check("R9 channel 2 midscale", int'(tgt_codes), 24'h800000);
      wr(2, 8'h27); tick(2);
      wr(2, 8'h20); tick(2);

      cur_req = "R10";
      wr(3, 8'h07); tick(2);
      check("R10 address 3 ignored", int'(tgt_codes), 0);

      tick(5);
      finish_run();
   end
endmodule